// File: doc/BRIEF.md
# GPIO Output/Input Register Block with Atomic Set and Clear

This block is a bus-mapped general purpose I/O register file for 22 pins. Software drives the output pins in one of two ways. It can write the output register directly. It can also write one of two aliases that atomically raise or lower only the bits written as 1, so no read-modify-write sequence is needed.

Every write honours the bus byte enables lane by lane. The pin inputs are brought into the clock domain through a two-stage synchronizer and can be read back through the input register.

Whenever a write actually alters the output pins, the block emits a single-cycle change event. The event carries a mask of the pins that flipped and the new output value, so that downstream logic such as pin models or trace capture can follow the output state without polling. The bus is a plain synchronous request interface. A write or read strobe is accepted in the cycle it is high, and read data is returned one cycle later.

Top module: `gpio_setclr_regs`

## Requirements
- R1: While reset is held, and after it is released, `pin_out` is 0, `chg_valid` is low and `bus_rdata` is 0. Reset itself never produces a change event.
- R2: A write to byte address 0x04 loads the output register from the enabled lanes. A read of 0x04 returns the current output state on `bus_rdata` in the cycle after the read strobe.
- R3: A write to byte address 0x08 sets every output bit whose written bit is 1 in an enabled lane. All other bits are left unchanged.
- R4: A write to byte address 0x0C clears every output bit whose written bit is 1 in an enabled lane. All other bits are left unchanged.
- R5: Byte enable bit k gates data bits 8k+7..8k for all three writable registers. For example, `bus_be`=4'b0010 affects only output bits 15..8.
- R6: Only pins 0..21 exist. Data bits 31..22 written to any register are ignored, and the output read returns 0 in bits 31..22.
- R7: Reads of the set alias, the clear alias and any unmapped or misaligned address return 0. Writes to unmapped addresses leave the outputs unchanged.
- R8: A read of byte address 0x20 (pin enable) always returns 0x000000FF, and writes to it have no effect.
- R9: A read of byte address 0x3C returns the synchronized inputs in bits 21..0. An input value first sampled at clock edge E is returned by a read strobe sampled at edge E+2, while a read sampled at E+1 still returns the previous value.
- R10: When a write changes the output, `chg_valid` is high for exactly the cycle after the write edge. In that cycle `chg_mask` equals the old output XOR the new output, and `chg_value` equals the new output, which also appears on `pin_out`.
- R11: A write that leaves the output value unchanged, such as setting a bit that is already set, produces no change event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 12 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte lane enables for writes |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after the read strobe, held otherwise |
| pin_in | input | 22 | Asynchronous pin inputs |
| pin_out | output | 22 | Output pin drive |
| chg_valid | output | 1 | One-cycle output change event |
| chg_mask | output | 22 | Pins that flipped in the change event |
| chg_value | output | 22 | Output value after the change |

## Verification
Writes take effect at the edge that samples the strobe. The new `pin_out` and any change event are both due in the cycle after that edge, and read data is due in the cycle after the read edge. The input register trails the pins by two edges, so a read sampled one edge after the first synchronizer edge must still return the old value. The driver tasks stamp every expected item with the cycle number in which it is due, and the monitor samples on the falling edge. The monitor compares an item only in its stamped cycle and flags any change pulse that no write predicted.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

  // Word-aligned register offsets; software depends on these positions.
  localparam logic [11:0] OFS_OUT = 12'h004;
  localparam logic [11:0] OFS_SET = 12'h008;
  localparam logic [11:0] OFS_CLR = 12'h00C;
  localparam logic [11:0] OFS_EN  = 12'h020;
  localparam logic [11:0] OFS_IN  = 12'h03C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_OUT,
    SEL_SET,
    SEL_CLR,
    SEL_EN,
    SEL_IN
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [11:0] addr);
    reg_sel_e s;
    unique case (addr)
      OFS_OUT: s = SEL_OUT;
      OFS_SET: s = SEL_SET;
      OFS_CLR: s = SEL_CLR;
      OFS_EN:  s = SEL_EN;
      OFS_IN:  s = SEL_IN;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned W = 22
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);

  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;

endmodule

// File: rtl/gpio_out_reg.sv
module gpio_out_reg #(
  parameter int unsigned NPINS = 22,
  parameter int unsigned DW    = 32,
  localparam int unsigned BEW  = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_out,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [DW-1:0]    wdata,
  input  logic [BEW-1:0]   be,
  output logic [NPINS-1:0] out_q,
  output logic             chg_valid_q,
  output logic [NPINS-1:0] chg_mask_q,
  output logic [NPINS-1:0] chg_value_q
);

  logic [DW-1:0]    lane_m;
  logic [DW-1:0]    wd_m;
  logic [NPINS-1:0] lm_p;
  logic [NPINS-1:0] wd_p;
  logic [NPINS-1:0] out_d;
  logic [NPINS-1:0] flip_d;
  logic             out_en;
  logic             chg_d;
  logic             unused_hi;

  for (genvar i = 0; i < BEW; i++) begin : g_lane
    assign lane_m[i*8 +: 8] = {8{be[i]}};
  end

  assign wd_m      = wdata & lane_m;
  assign lm_p      = lane_m[NPINS-1:0];
  assign wd_p      = wd_m[NPINS-1:0];
  assign unused_hi = ^wd_m[DW-1:NPINS];

  assign out_en = wr_out | wr_set | wr_clr;

  always_comb begin
    out_d = out_q;
    if (wr_out) begin
      out_d = (out_q & ~lm_p) | wd_p;
    end else if (wr_set) begin
      out_d = out_q | wd_p;
    end else if (wr_clr) begin
      out_d = out_q & ~wd_p;
    end
  end

  assign flip_d = out_d ^ out_q;
  assign chg_d  = out_en && (|flip_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q       <= '0;
      chg_valid_q <= 1'b0;
      chg_mask_q  <= '0;
      chg_value_q <= '0;
    end else begin
      if (out_en) begin
        out_q <= out_d;
      end
      chg_valid_q <= chg_d;
      if (chg_d) begin
        chg_mask_q  <= flip_d;
        chg_value_q <= out_d;
      end
    end
  end

  AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_out || wr_set || wr_clr) |=> $stable(out_q)); // R2
  AST_SET_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> ((out_q & $past(wd_p)) == $past(wd_p))); // R3
  AST_CLR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> ((out_q & $past(wd_p)) == '0)); // R4
  AST_CHG_MASK_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid_q |-> (chg_mask_q == (out_q ^ $past(out_q)))); // R10
  AST_CHG_VALUE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    chg_valid_q |-> (chg_value_q == out_q)); // R10
  AST_NO_SILENT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(out_en) |-> !chg_valid_q); // R11

endmodule

// File: rtl/gpio_rd_path.sv
module gpio_rd_path
  import gpio_pkg::*;
#(
  parameter int unsigned   NPINS      = 22,
  parameter int unsigned   DW         = 32,
  parameter logic [DW-1:0] ENABLE_VAL = 32'h0000_00FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  reg_sel_e         sel,
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] in_q,
  output logic [DW-1:0]    rdata_q
);

  localparam int unsigned PADW = DW - NPINS;

  logic [DW-1:0] rdata_d;

  always_comb begin
    unique case (sel)
      SEL_OUT: rdata_d = {{PADW{1'b0}}, out_q};
      SEL_IN:  rdata_d = {{PADW{1'b0}}, in_q};
      SEL_EN:  rdata_d = ENABLE_VAL;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd) begin
      rdata_q <= rdata_d;
    end
  end

  AST_ENABLE_CONST: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_EN) |=> (rdata_q == ENABLE_VAL)); // R8
  AST_ALIAS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && (sel == SEL_SET || sel == SEL_CLR || sel == SEL_NONE)) |=> (rdata_q == '0)); // R7
  AST_OUT_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && sel == SEL_OUT) |=> (rdata_q[DW-1:NPINS] == '0)); // R6

endmodule

// File: rtl/gpio_setclr_regs.sv
module gpio_setclr_regs
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS = 22,
  parameter int unsigned AW    = 12,
  parameter int unsigned DW    = 32,
  localparam int unsigned BEW  = DW / 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  input  logic [BEW-1:0]   bus_be,
  input  logic             bus_wr,
  input  logic             bus_rd,
  output logic [DW-1:0]    bus_rdata,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic             chg_valid,
  output logic [NPINS-1:0] chg_mask,
  output logic [NPINS-1:0] chg_value
);

  logic             rst_meta_q;
  logic             rst_s;
  logic [11:0]      addr12;
  reg_sel_e         sel;
  logic             wr_out;
  logic             wr_set;
  logic             wr_clr;
  logic [NPINS-1:0] in_sync;

  // Asynchronous assert, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s      <= rst_meta_q;
    end
  end

  if (AW >= 12) begin : g_addr_wide
    assign addr12 = (bus_addr[AW-1:0] >> 0) < (1 << 12) ? bus_addr[11:0] : 12'hFFF;
  end else begin : g_addr_narrow
    assign addr12 = {{(12-AW){1'b0}}, bus_addr};
  end

  assign sel    = decode_addr(addr12);
  assign wr_out = bus_wr && (sel == SEL_OUT);
  assign wr_set = bus_wr && (sel == SEL_SET);
  assign wr_clr = bus_wr && (sel == SEL_CLR);

  gpio_in_sync #(.W(NPINS)) u_in_sync (
    .clk      (clk),
    .rst_n    (rst_s),
    .async_in (pin_in),
    .sync_out (in_sync)
  );

  gpio_out_reg #(.NPINS(NPINS), .DW(DW)) u_out_reg (
    .clk         (clk),
    .rst_n       (rst_s),
    .wr_out      (wr_out),
    .wr_set      (wr_set),
    .wr_clr      (wr_clr),
    .wdata       (bus_wdata),
    .be          (bus_be),
    .out_q       (pin_out),
    .chg_valid_q (chg_valid),
    .chg_mask_q  (chg_mask),
    .chg_value_q (chg_value)
  );

  gpio_rd_path #(.NPINS(NPINS), .DW(DW)) u_rd_path (
    .clk     (clk),
    .rst_n   (rst_s),
    .rd      (bus_rd),
    .sel     (sel),
    .out_q   (pin_out),
    .in_q    (in_sync),
    .rdata_q (bus_rdata)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_s |-> (!chg_valid && pin_out == '0)); // R1

endmodule

// File: tb/gpio_setclr_regs_bench.sv
module gpio_setclr_regs_bench;

  logic        clk;
  logic        rst_n;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [3:0]  bus_be;
  logic        bus_wr;
  logic        bus_rd;
  logic [31:0] bus_rdata;
  logic [21:0] pin_in;
  logic [21:0] pin_out;
  logic        chg_valid;
  logic [21:0] chg_mask;
  logic [21:0] chg_value;

  gpio_setclr_regs u_gpio_setclr_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_be    (bus_be),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .chg_valid (chg_valid),
    .chg_mask  (chg_mask),
    .chg_value (chg_value)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    logic [31:0] exp;
    string       tag;
  } rd_item_t;

  typedef struct {
    int          due;
    logic [21:0] mask;
    logic [21:0] val;
    string       tag;
  } chg_item_t;

  rd_item_t    rdq[$];
  chg_item_t   chq[$];
  int          checks = 0;
  int          errors = 0;
  logic [21:0] out_m;
  bit          done = 0;

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d,
                           input logic [3:0] be, input string tag);
    logic [31:0] lm;
    logic [21:0] nv;
    chg_item_t   it;
    lm = {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
    nv = out_m;
    case (a)
      12'h004: nv = (out_m & ~lm[21:0]) | (d[21:0] & lm[21:0]);
      12'h008: nv = out_m | (d[21:0] & lm[21:0]);
      12'h00C: nv = out_m & ~(d[21:0] & lm[21:0]);
      default: nv = out_m;
    endcase
    it.due  = cyc + 1;
    it.mask = nv ^ out_m;
    it.val  = nv;
    it.tag  = tag;
    chq.push_back(it);
    out_m     = nv;
    bus_addr  = a;
    bus_wdata = d;
    bus_be    = be;
    bus_wr    = 1'b1;
    tick();
    bus_wr    = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, input logic [31:0] exp,
                          input string tag);
    rd_item_t it;
    it.due = cyc + 1;
    it.exp = exp;
    it.tag = tag;
    rdq.push_back(it);
    bus_addr = a;
    bus_rd   = 1'b1;
    tick();
    bus_rd   = 1'b0;
  endtask

  // Monitor: pops scoreboard items in the cycle they are due.
  always @(negedge clk) begin : mon
    chg_item_t ci;
    rd_item_t  ri;
    if (rst_n && !done) begin
      if (chq.size() > 0 && chq[0].due == cyc) begin
        ci = chq.pop_front();
        checks++;
        if (ci.mask == '0) begin
          if (chg_valid !== 1'b0 || pin_out !== ci.val) begin
            errors++;
            $display("FAIL %s: valid=%0b pin_out=%h expected valid=0 pin_out=%h",
                     ci.tag, chg_valid, pin_out, ci.val);
          end
        end else if (chg_valid !== 1'b1 || chg_mask !== ci.mask ||
                     chg_value !== ci.val || pin_out !== ci.val) begin
          errors++;
          $display("FAIL %s: valid=%0b mask=%h value=%h pin_out=%h expected valid=1 mask=%h value=%h",
                   ci.tag, chg_valid, chg_mask, chg_value, pin_out, ci.mask, ci.val);
        end
      end else if (chg_valid !== 1'b0) begin
        checks++;
        errors++;
        $display("FAIL R11: unexpected change pulse mask=%h expected no pulse", chg_mask);
      end
      if (rdq.size() > 0 && rdq[0].due == cyc) begin
        ri = rdq.pop_front();
        checks++;
        if (bus_rdata !== ri.exp) begin
          errors++;
          $display("FAIL %s: rdata=%h expected %h", ri.tag, bus_rdata, ri.exp);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    rst_n     = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_be    = '0;
    bus_wr    = 1'b0;
    bus_rd    = 1'b0;
    pin_in    = 22'h2A5A5A;
    out_m     = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++; // R1 reset state
    if (pin_out !== '0 || chg_valid !== 1'b0 || bus_rdata !== '0) begin
      errors++;
      $display("FAIL R1: pin_out=%h chg_valid=%0b rdata=%h expected 0 0 0",
               pin_out, chg_valid, bus_rdata);
    end
    tick();
    rst_n = 1'b1;
    repeat (4) tick();

    bus_read(12'h004, 32'h0, "R1 output after reset");
    bus_read(12'h020, 32'h0000_00FF, "R8 enable read");
    bus_read(12'h03C, 32'h002A_5A5A, "R9 input read");

    bus_write(12'h004, 32'h0000_1234, 4'hF, "R2 output write");
    bus_read(12'h004, 32'h0000_1234, "R2 output readback");
    bus_write(12'h008, 32'h0000_0100, 4'hF, "R3 set bit 8");
    bus_write(12'h008, 32'h0000_0100, 4'hF, "R11 set already set");
    bus_write(12'h00C, 32'h0000_0030, 4'hF, "R4 clear bits 5:4");
    bus_write(12'h00C, 32'h0000_0030, 4'hF, "R11 clear already clear");
    bus_read(12'h004, 32'h0000_1304, "R4 output readback");
    bus_write(12'h004, 32'hFFFF_FFFF, 4'b0010, "R5 lane 1 only");
    bus_write(12'h008, 32'h00FF_00FF, 4'b0100, "R5 R6 set lane 2");
    bus_read(12'h004, 32'h003F_FF04, "R6 output upper bits zero");
    bus_write(12'h004, 32'hFFC0_0000, 4'hF, "R6 upper data ignored");
    bus_read(12'h004, 32'h0, "R6 output cleared");

    bus_read(12'h008, 32'h0, "R7 set alias reads 0");
    bus_read(12'h00C, 32'h0, "R7 clear alias reads 0");
    bus_read(12'h010, 32'h0, "R7 unmapped reads 0");
    bus_write(12'h010, 32'hFFFF_FFFF, 4'hF, "R7 unmapped write ignored");
    bus_write(12'h020, 32'hFFFF_FFFF, 4'hF, "R8 enable write ignored");
    bus_read(12'h004, 32'h0, "R7 output unchanged");
    bus_read(12'h020, 32'h0000_00FF, "R8 enable after write");

    pin_in = 22'h155555;
    tick();
    bus_read(12'h03C, 32'h002A_5A5A, "R9 one edge after sample still old");
    bus_read(12'h03C, 32'h0015_5555, "R9 two edges after sample new");

    bus_write(12'h004, 32'h002A_AAAA, 4'hF, "R10 multi-bit toggle");
    bus_write(12'h00C, 32'h0000_000A, 4'b0001, "R10 clear two bits");
    bus_read(12'h004, 32'h002A_AAA0, "R2 final readback");

    repeat (3) tick();
    checks++;
    if (chq.size() != 0 || rdq.size() != 0) begin
      errors++;
      $display("FAIL R10: pending items chg=%0d rd=%0d expected 0 0",
               chq.size(), rdq.size());
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule